// File: doc/BRIEF.md
# Serial Divider-Ratio Load Register

This block is the synthesizer-side receiver for divider programming. A host shifts words in, most significant bit first, on a data line and a serial clock line. It then pulses a strobe line to apply the word. The control bit is always sent last. The strobe can be raised together with a measurement trigger, so the host can tie a frequency change to the start of a measurement.

Two word formats share one shift path. The control bit, which is the word's least significant bit, is examined at the strobe.

- A control bit of 1 marks a 16-bit reference word. It carries a 14-bit reference ratio and a prescaler select bit. Select 0 means the 128/129 modulus and select 1 means the 64/65 modulus.
- A control bit of 0 marks a 19-bit main word. It carries an 11-bit N ratio and a 7-bit A swallow count.

The receiver counts the bits shifted since the previous strobe and discards a word whose length does not match its control bit. The held ratios feed the divider chain and change only when a strobe is accepted.

All three serial lines are sampled by the system clock `clk_i`. A serial clock pulse or a strobe pulse must therefore stay high for at least one `clk_i` cycle and stay low for at least one `clk_i` cycle.

Top module: `divratio_loader`

## Requirements
- R1: After reset is asserted, `ref_ratio_o`, `presc_sel_o`, `n_ratio_o` and `a_count_o` are all zero.
- R2: Each rising edge of `ser_clk_i`, as seen by `clk_i`, shifts in the level of `ser_data_i` and adds one to the bit count. Bits arrive most significant first, so the last bit shifted is the word's bit 0, which is the control bit.
- R3: A strobe accepts a reference word when the control bit is 1 and exactly 16 bits arrived since the previous strobe. The transmission order is prescaler select, then reference ratio bits 13 down to 0, then the control bit. On acceptance `ref_ratio_o` and `presc_sel_o` load, and `n_ratio_o` and `a_count_o` keep their values.
- R4: A strobe accepts a main word when the control bit is 0 and exactly 19 bits arrived since the previous strobe. The transmission order is N bits 10 down to 0, then A bits 6 down to 0, then the control bit. On acceptance `n_ratio_o` and `a_count_o` load, and `ref_ratio_o` and `presc_sel_o` keep their values.
- R5: A strobe whose bit count does not match the length that its control bit selects leaves every output unchanged. This covers short words, long words (the count saturates), a zero count, and the wrong control bit for the length.
- R6: Outputs change only on an accepted strobe. Shifting, including a complete word that is never strobed, never alters them.
- R7: Only the rising edge of `ser_load_i` acts. It clears the bit count, so the next word is counted from that strobe. Holding the strobe high does not load again, and shifting continues normally while the strobe is held high.
- R8: New values appear on the outputs after the first `clk_i` rising edge that samples `ser_load_i` high following a low sample.
- R9: A rising edge of `ser_clk_i` that is seen in the same `clk_i` cycle as a strobe rising edge is not shifted. The strobe uses the word held before that cycle, and the count restarts at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples the serial lines |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ser_clk_i | input | 1 | Serial bit clock; a bit is taken on its rising edge |
| ser_data_i | input | 1 | Serial data, most significant bit first |
| ser_load_i | input | 1 | Strobe; a rising edge applies the shifted word |
| ref_ratio_o | output | 14 | Held reference divider ratio |
| presc_sel_o | output | 1 | Prescaler select: 0 for 128/129, 1 for 64/65 |
| n_ratio_o | output | 11 | Held N divider ratio |
| a_count_o | output | 7 | Held A swallow count |

## Verification
The edge detectors add one register stage. A serial line raised before a `clk_i` rising edge therefore takes effect at that edge. An accepted strobe shows its values on the outputs from that same edge onward. The bench drives the inputs and samples the outputs at falling edges of `clk_i`. It checks R8 at two points: at the falling edge where the strobe is raised, when the old values must still be present, and at the next falling edge, when the new ones must be present. Every other check follows a strobe by at least one full cycle. All other checks sweep word contents and word lengths and compare against values the bench computes from the word it sent.

// File: rtl/divload_pkg.sv
package divload_pkg;
  localparam int unsigned DEF_R_W = 14;
  localparam int unsigned DEF_A_W = 7;
  localparam int unsigned DEF_N_W = 11;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/divload_edge.sv
module divload_edge #(
  parameter int unsigned W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] lvl_q;

  for (genvar g = 0; g < W; g++) begin : g_line
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) lvl_q[g] <= 1'b0;
      else         lvl_q[g] <= lvl_i[g];
    end
    assign rise_o[g] = lvl_i[g] & ~lvl_q[g];
  end
endmodule

// File: rtl/divload_shift.sv
module divload_shift #(
  parameter int unsigned SR_W  = 19,
  parameter int unsigned CNT_W = 5,
  parameter int unsigned SAT   = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             shift_i,
  input  logic             clear_i,
  input  logic             bit_i,
  output logic [SR_W-1:0]  sr_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CntSat = CNT_W'(SAT);

  logic [SR_W-1:0]  sr_q;
  logic [CNT_W-1:0] cnt_q;

  // clear wins over a coincident shift: that bit is dropped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (clear_i) begin
      cnt_q <= '0;
    end else if (shift_i) begin
      sr_q  <= {sr_q[SR_W-2:0], bit_i};
      cnt_q <= (cnt_q == CntSat) ? cnt_q : cnt_q + CNT_W'(1);
    end
  end

  assign sr_o  = sr_q;
  assign cnt_o = cnt_q;
endmodule

// File: rtl/divload_regs.sv
module divload_regs #(
  parameter int unsigned R_W   = 14,
  parameter int unsigned A_W   = 7,
  parameter int unsigned N_W   = 11,
  parameter int unsigned SR_W  = 19,
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             strobe_i,
  input  logic [SR_W-1:0]  sr_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [R_W-1:0]   ref_ratio_o,
  output logic             presc_sel_o,
  output logic [N_W-1:0]   n_ratio_o,
  output logic [A_W-1:0]   a_count_o
);
  localparam int unsigned REF_LEN = R_W + 2;
  localparam int unsigned NA_LEN  = A_W + N_W + 1;

  logic ref_take, na_take;

  assign ref_take = strobe_i &  sr_i[0] & (cnt_i == CNT_W'(REF_LEN));
  assign na_take  = strobe_i & ~sr_i[0] & (cnt_i == CNT_W'(NA_LEN));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_ratio_o <= '0;
      presc_sel_o <= 1'b0;
    end else if (ref_take) begin
      ref_ratio_o <= sr_i[R_W:1];
      presc_sel_o <= sr_i[R_W+1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      n_ratio_o <= '0;
      a_count_o <= '0;
    end else if (na_take) begin
      a_count_o <= sr_i[A_W:1];
      n_ratio_o <= sr_i[A_W+N_W:A_W+1];
    end
  end
endmodule

// File: rtl/divratio_loader.sv
module divratio_loader
  import divload_pkg::*;
#(
  parameter int unsigned R_W = DEF_R_W,
  parameter int unsigned A_W = DEF_A_W,
  parameter int unsigned N_W = DEF_N_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           ser_clk_i,
  input  logic           ser_data_i,
  input  logic           ser_load_i,
  output logic [R_W-1:0] ref_ratio_o,
  output logic           presc_sel_o,
  output logic [N_W-1:0] n_ratio_o,
  output logic [A_W-1:0] a_count_o
);
  localparam int unsigned REF_LEN = R_W + 2;
  localparam int unsigned NA_LEN  = A_W + N_W + 1;
  localparam int unsigned SR_W    = max2(REF_LEN, NA_LEN);
  localparam int unsigned SAT     = SR_W + 1;
  localparam int unsigned CNT_W   = $clog2(SAT + 1);

  logic [1:0]       rise;
  logic [SR_W-1:0]  sr_q;
  logic [CNT_W-1:0] cnt_q;

  divload_edge #(.W(2)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  ({ser_load_i, ser_clk_i}),
    .rise_o (rise)
  );

  divload_shift #(.SR_W(SR_W), .CNT_W(CNT_W), .SAT(SAT)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (rise[0]),
    .clear_i (rise[1]),
    .bit_i   (ser_data_i),
    .sr_o    (sr_q),
    .cnt_o   (cnt_q)
  );

  divload_regs #(.R_W(R_W), .A_W(A_W), .N_W(N_W), .SR_W(SR_W), .CNT_W(CNT_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .strobe_i    (rise[1]),
    .sr_i        (sr_q),
    .cnt_i       (cnt_q),
    .ref_ratio_o (ref_ratio_o),
    .presc_sel_o (presc_sel_o),
    .n_ratio_o   (n_ratio_o),
    .a_count_o   (a_count_o)
  );
endmodule

// File: rtl/divload_checker.sv
module divload_checker #(
  parameter int unsigned R_W   = 14,
  parameter int unsigned A_W   = 7,
  parameter int unsigned N_W   = 11,
  parameter int unsigned SR_W  = 19,
  parameter int unsigned CNT_W = 5,
  parameter int unsigned SAT   = 20
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ser_clk_i,
  input logic             ser_data_i,
  input logic             ser_load_i,
  input logic [SR_W-1:0]  sr_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [R_W-1:0]   ref_ratio_o,
  input logic             presc_sel_o,
  input logic [N_W-1:0]   n_ratio_o,
  input logic [A_W-1:0]   a_count_o
);
  localparam int unsigned REF_LEN = R_W + 2;
  localparam int unsigned NA_LEN  = A_W + N_W + 1;

  logic ld_q, ck_q, ld_rise, ck_rise, ref_ok, na_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ld_q <= 1'b0;
      ck_q <= 1'b0;
    end else begin
      ld_q <= ser_load_i;
      ck_q <= ser_clk_i;
    end
  end

  assign ld_rise = ser_load_i & ~ld_q;
  assign ck_rise = ser_clk_i & ~ck_q;
  assign ref_ok  = sr_i[0]  && (cnt_i == CNT_W'(REF_LEN));
  assign na_ok   = !sr_i[0] && (cnt_i == CNT_W'(NA_LEN));

  a_r2_shift_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ck_rise && !ld_rise |=> sr_i[0] == $past(ser_data_i));

  a_r2_count_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ck_rise && !ld_rise && (cnt_i < CNT_W'(SAT)) |=> cnt_i == $past(cnt_i) + CNT_W'(1));

  a_r2_count_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i <= CNT_W'(SAT));

  a_r3_ref_take: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_rise && ref_ok |=> ref_ratio_o == $past(sr_i[R_W:1]) && presc_sel_o == $past(sr_i[R_W+1]));

  a_r4_na_take: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_rise && na_ok |=> a_count_o == $past(sr_i[A_W:1]) && n_ratio_o == $past(sr_i[A_W+N_W:A_W+1]));

  a_r5_ref_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_rise && !ref_ok |=> $stable(ref_ratio_o) && $stable(presc_sel_o));

  a_r5_na_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_rise && !na_ok |=> $stable(n_ratio_o) && $stable(a_count_o));

  a_r6_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_rise |=> $stable(ref_ratio_o) && $stable(presc_sel_o) && $stable(n_ratio_o) && $stable(a_count_o));

  a_r7_count_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_rise |=> cnt_i == '0);

  a_r9_no_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_rise |=> $stable(sr_i));
endmodule

bind divratio_loader divload_checker #(
  .R_W(R_W), .A_W(A_W), .N_W(N_W), .SR_W(SR_W), .CNT_W(CNT_W), .SAT(SAT)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ser_clk_i   (ser_clk_i),
  .ser_data_i  (ser_data_i),
  .ser_load_i  (ser_load_i),
  .sr_i        (sr_q),
  .cnt_i       (cnt_q),
  .ref_ratio_o (ref_ratio_o),
  .presc_sel_o (presc_sel_o),
  .n_ratio_o   (n_ratio_o),
  .a_count_o   (a_count_o)
);

// File: tb/tb_divratio_loader.sv
module tb_divratio_loader;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_load = 1'b0;
  logic [13:0] ref_ratio;
  logic        presc_sel;
  logic [10:0] n_ratio;
  logic [6:0]  a_count;

  logic [13:0] exp_r = '0;
  logic        exp_p = 1'b0;
  logic [10:0] exp_n = '0;
  logic [6:0]  exp_a = '0;

  int runs = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  divratio_loader dut (
    .clk_i(clk), .rst_ni(rst_n), .ser_clk_i(ser_clk), .ser_data_i(ser_data),
    .ser_load_i(ser_load), .ref_ratio_o(ref_ratio), .presc_sel_o(presc_sel),
    .n_ratio_o(n_ratio), .a_count_o(a_count)
  );

  task automatic check(input string req);
    runs++;
    if (ref_ratio !== exp_r || presc_sel !== exp_p || n_ratio !== exp_n || a_count !== exp_a) begin
      fails++;
      $display("FAIL %s: got r=%0h p=%0b n=%0h a=%0h, expected r=%0h p=%0b n=%0h a=%0h",
               req, ref_ratio, presc_sel, n_ratio, a_count, exp_r, exp_p, exp_n, exp_a);
    end
  endtask

  task automatic shift_word(input logic [31:0] w, input int len);
    for (int i = len - 1; i >= 0; i--) begin
      @(negedge clk); ser_data = w[i]; ser_clk = 1'b1;
      @(negedge clk);
      @(negedge clk); ser_clk = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic strobe();
    @(negedge clk); ser_load = 1'b1;
    @(negedge clk); ser_load = 1'b0;
    @(negedge clk);
  endtask

  function automatic logic [31:0] ref_word(input logic p, input logic [13:0] r);
    return {16'h0, p, r, 1'b1};
  endfunction

  function automatic logic [31:0] na_word(input logic [10:0] n, input logic [6:0] a);
    return {13'h0, n, a, 1'b0};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish");
      $display("  [TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 after release");

    // R3 sweep of reference words
    for (int k = 0; k < 24; k++) begin
      logic [13:0] rv;
      rv = 14'(k * 1237 + 3);
      if (k == 22) rv = 14'h3fff;
      if (k == 23) rv = 14'h0000;
      shift_word(ref_word(k[0], rv), 16);
      strobe();
      exp_r = rv; exp_p = k[0];
      check("R3 reference word");
    end

    // R4 sweep of main words
    for (int k = 0; k < 24; k++) begin
      logic [10:0] nv;
      logic [6:0]  av;
      nv = 11'(k * 163 + 5);
      av = 7'(k * 37 + 1);
      if (k == 23) begin nv = 11'h7ff; av = 7'h7f; end
      shift_word(na_word(nv, av), 19);
      strobe();
      exp_n = nv; exp_a = av;
      check("R4 main word");
    end

    // R5 wrong lengths discard
    shift_word(ref_word(1'b1, 14'h1555), 15);   strobe(); check("R5 ref short");
    shift_word({ref_word(1'b0, 14'h0aaa)}, 17); strobe(); check("R5 ref long");
    shift_word(na_word(11'h123, 7'h45), 18);    strobe(); check("R5 main short");
    shift_word(na_word(11'h321, 7'h54), 20);    strobe(); check("R5 main long");
    shift_word(na_word(11'h0f0, 7'h0f) & 32'hffff, 16); strobe(); check("R5 ctrl 0 with 16 bits");
    shift_word({13'h0, 18'h2abcd, 1'b1}, 19);   strobe(); check("R5 ctrl 1 with 19 bits");
    strobe(); check("R5 zero bits");
    shift_word(32'h0001_2345 | ref_word(1'b1, 14'h0123), 32); strobe(); check("R5 saturated count");

    // R6 full word without strobe leaves outputs alone
    shift_word(ref_word(1'b0, 14'h2468), 16);
    check("R6 shifted, no strobe");
    strobe();
    exp_r = 14'h2468; exp_p = 1'b0;
    check("R6 applied on strobe");

    // R7 strobe held high: only its rising edge acts
    @(negedge clk); ser_load = 1'b1;
    shift_word(na_word(11'h5a5, 7'h33), 19);
    check("R7 held strobe does not reload");
    @(negedge clk); ser_load = 1'b0;
    @(negedge clk);
    check("R7 strobe fall has no effect");
    strobe();
    exp_n = 11'h5a5; exp_a = 7'h33;
    check("R7 count started at previous strobe");

    // R8 latency
    shift_word(ref_word(1'b1, 14'h1c3e), 16);
    @(negedge clk); ser_load = 1'b1;
    check("R8 old values before strobe edge");
    @(negedge clk); ser_load = 1'b0;
    exp_r = 14'h1c3e; exp_p = 1'b1;
    check("R8 new values one edge later");

    // R9 coincident clock and strobe
    shift_word(na_word(11'h0aa, 7'h55), 19);
    @(negedge clk); ser_data = 1'b1; ser_clk = 1'b1; ser_load = 1'b1;
    @(negedge clk);
    @(negedge clk); ser_clk = 1'b0; ser_load = 1'b0;
    @(negedge clk);
    exp_n = 11'h0aa; exp_a = 7'h55;
    check("R9 strobe uses prior word");
    shift_word(ref_word(1'b0, 14'h0777), 16);
    strobe();
    exp_r = 14'h0777; exp_p = 1'b0;
    check("R9 coincident bit not counted");

    // R1 reset in mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    exp_r = '0; exp_p = 1'b0; exp_n = '0; exp_a = '0;
    check("R1 reset clears held ratios");
    rst_n = 1'b1;

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule